// File: doc/BRIEF.md
# Masked Ternary Search Table Engine

The engine holds a table of 68-bit words, each with a local don't-care mask and a live bit. A host compares a search key against the whole table. It gets back the lowest table index whose word matches the key under both the local mask and a global mask. A search is a two-cycle command. In the first cycle (`srch_a`) the engine takes the key and the index of a global mask register pair. In the second cycle (`srch_b`) it takes the same key again and the index of a comparand register pair. The key is then stored into both registers of that pair.

The comparison uses the table contents at the cycle A edge. The winning index comes out of a fixed-latency pipeline with an address strobe. A second pair of strobes (result valid and found) can be delayed further by a small number of cycles chosen on `extra_lat`. A separate host write port loads entries, local masks, global masks and comparand registers. Commands may be issued back to back, one every two cycles.

Top module: `tcam_search_top`

## Requirements
- R1: A search starts when `srch_a` is high and no search was accepted in the previous cycle. Its second cycle is `srch_b` in the next cycle. An `srch_b` that does not directly follow an accepted `srch_a` is ignored: it produces no strobe and writes no comparand register.
- R2: A key bit takes part in the comparison only when it is 0 in both the entry's local mask and the effective global mask. A mask bit of 1 means don't care. The effective global mask is the OR of registers 2p and 2p+1, where p is the `gm_pair` value sampled in cycle A. Entries whose live bit is 0 never match.
- R3: When several entries match, the lowest index wins.
- R4: Cycle B writes the key on `key_in` into comparand registers 2c and 2c+1, where c is `cr_pair`. If a host write targets one of those registers in the same cycle, the search value wins. Register i is read combinationally on `cr_rd_data` when `cr_rd_idx` = i.
- R5: `win_stb` and `win_addr` are registered exactly 5 clock edges after the edge that accepts cycle A.
- R6: `res_valid` and `res_found` follow `win_stb` by exactly `extra_lat` cycles (0 to 7). `extra_lat` is held constant while searches are in flight.
- R7: On a miss, `win_addr` is 0, `res_found` is 0 and `res_valid` is still 1. `res_found` is never high without `res_valid`.
- R8: Searches issued back to back, one every two cycles, each give one result, in issue order, with no strobe on two consecutive cycles.
- R9: The write port is controlled by `wr_kind`. Value 0 loads entry `wr_addr` with `wr_data` and its live bit with `wr_live`. Value 1 loads the entry's local mask. Value 2 loads global mask register `wr_addr[2:0]`. Value 3 loads comparand register `wr_addr[2:0]`.
- R10: A host write in cycle A or cycle B of a search does not change that search's result. It affects only later searches.
- R11: Reset clears all live bits, local masks, global masks, comparand registers and strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| srch_a | input | 1 | First cycle of a search command |
| srch_b | input | 1 | Second cycle of a search command |
| key_in | input | 68 | Search key (same value in both cycles) |
| gm_pair | input | 2 | Global mask pair index, sampled in cycle A |
| cr_pair | input | 2 | Comparand pair index, sampled in cycle B |
| wr_en | input | 1 | Host write strobe |
| wr_kind | input | 2 | Write target selector |
| wr_addr | input | 6 | Entry or register index |
| wr_data | input | 68 | Write data |
| wr_live | input | 1 | Live bit for entry data writes |
| extra_lat | input | 3 | Extra delay of valid/found after the address strobe |
| cr_rd_idx | input | 3 | Comparand register read index |
| cr_rd_data | output | 68 | Comparand register read data |
| win_addr | output | 6 | Lowest matching index, 0 on miss |
| win_stb | output | 1 | Address strobe |
| res_valid | output | 1 | Result valid strobe |
| res_found | output | 1 | Result hit strobe |

## Verification
Host writes can fall in the same cycle as either half of a search command. The bench provokes this in two ways. First, it writes a matching entry during cycle A and expects the old miss from that search and a hit from the next one. Second, it writes a comparand register during the cycle B that stores the key into the same register, and expects the key to be read back. A second collision is the address strobe of one search landing while the next command is being accepted. The back-to-back sweep covers it: every result must carry its own address at its own cycle.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  localparam int KEY_W = 68;
  typedef logic [KEY_W-1:0] word_t;

  typedef enum logic [1:0] {
    WK_DATA  = 2'd0,
    WK_LMASK = 2'd1,
    WK_GMASK = 2'd2,
    WK_CMP   = 2'd3
  } wkind_e;

  // a key bit counts only when neither mask marks it don't-care
  function automatic logic entry_hit(word_t key, word_t data, word_t lmask,
                                     word_t gmask, logic live);
    return live && (((key ^ data) & ~(lmask | gmask)) == '0);
  endfunction

  // a bit masked in either register of a pair is masked
  function automatic word_t pair_mask(word_t even_q, word_t odd_q);
    return even_q | odd_q;
  endfunction
endpackage

// File: rtl/tcam_store.sv
module tcam_store import tcam_pkg::*; #(
  parameter int DEPTH = 64,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  wkind_e            wr_kind,
  input  logic [ADDR_W-1:0] wr_addr,
  input  word_t             wr_data,
  input  logic              wr_live,
  output word_t             ent_data  [DEPTH],
  output word_t             ent_lmask [DEPTH],
  output logic              ent_live  [DEPTH]
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        ent_data[i]  <= '0;
        ent_lmask[i] <= '0;
        ent_live[i]  <= 1'b0;
      end
    end else if (wr_en) begin
      if (wr_kind == WK_DATA) begin
        ent_data[wr_addr] <= wr_data;
        ent_live[wr_addr] <= wr_live;
      end else if (wr_kind == WK_LMASK) begin
        ent_lmask[wr_addr] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/tcam_regs.sv
module tcam_regs import tcam_pkg::*; #(
  parameter int NUM_GM = 8,
  parameter int NUM_CR = 8,
  localparam int GM_W = $clog2(NUM_GM),
  localparam int CR_W = $clog2(NUM_CR)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  wkind_e          wr_kind,
  input  logic [GM_W-1:0] wr_gm_idx,
  input  logic [CR_W-1:0] wr_cr_idx,
  input  word_t           wr_data,
  input  logic            cmp_fire,
  input  logic [CR_W-2:0] cmp_pair,
  input  word_t           cmp_key,
  output word_t           gm_q [NUM_GM],
  output word_t           cr_q [NUM_CR]
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_GM; i++) gm_q[i] <= '0;
      for (int i = 0; i < NUM_CR; i++) cr_q[i] <= '0;
    end else begin
      if (wr_en && wr_kind == WK_GMASK) gm_q[wr_gm_idx] <= wr_data;
      if (wr_en && wr_kind == WK_CMP)   cr_q[wr_cr_idx] <= wr_data;
      // search store comes last so it overrides a colliding host write
      if (cmp_fire) begin
        cr_q[{cmp_pair, 1'b0}] <= cmp_key;
        cr_q[{cmp_pair, 1'b1}] <= cmp_key;
      end
    end
  end
endmodule

// File: rtl/tcam_match.sv
module tcam_match import tcam_pkg::*; #(
  parameter int DEPTH = 64
) (
  input  word_t            key,
  input  word_t            gmask,
  input  word_t            ent_data  [DEPTH],
  input  word_t            ent_lmask [DEPTH],
  input  logic             ent_live  [DEPTH],
  output logic [DEPTH-1:0] hit_vec
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    assign hit_vec[g] = entry_hit(key, ent_data[g], ent_lmask[g], gmask, ent_live[g]);
  end
endmodule

// File: rtl/tcam_prienc.sv
module tcam_prienc #(
  parameter int DEPTH = 64,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]  vec,
  output logic [ADDR_W-1:0] idx,
  output logic              any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx = ADDR_W'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tcam_shift.sv
module tcam_shift #(
  parameter int W = 1,
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] taps [N+1]
);
  logic [W-1:0] stg [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) stg[i] <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < N; i++) stg[i] <= stg[i-1];
    end
  end

  always_comb begin
    taps[0] = din;
    for (int i = 0; i < N; i++) taps[i+1] = stg[i];
  end
endmodule

// File: rtl/tcam_search_top.sv
module tcam_search_top import tcam_pkg::*; #(
  parameter int DEPTH    = 64,
  parameter int NUM_GM   = 8,
  parameter int NUM_CR   = 8,
  parameter int BASE_LAT = 5,
  parameter int MAX_XL   = 7,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int GM_W   = $clog2(NUM_GM),
  localparam int CR_W   = $clog2(NUM_CR),
  localparam int GP_W   = GM_W - 1,
  localparam int CP_W   = CR_W - 1,
  localparam int XL_W   = $clog2(MAX_XL + 1),
  localparam int PIPE_W = ADDR_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srch_a,
  input  logic              srch_b,
  input  logic [KEY_W-1:0]  key_in,
  input  logic [GP_W-1:0]   gm_pair,
  input  logic [CP_W-1:0]   cr_pair,
  input  logic              wr_en,
  input  logic [1:0]        wr_kind,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [KEY_W-1:0]  wr_data,
  input  logic              wr_live,
  input  logic [XL_W-1:0]   extra_lat,
  input  logic [CR_W-1:0]   cr_rd_idx,
  output logic [KEY_W-1:0]  cr_rd_data,
  output logic [ADDR_W-1:0] win_addr,
  output logic              win_stb,
  output logic              res_valid,
  output logic              res_found
);
  wkind_e wk;
  assign wk = wkind_e'(wr_kind);

  // command sequencing events
  logic a_pend, a_fire, b_fire;
  assign a_fire = srch_a && !a_pend;
  assign b_fire = srch_b && a_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) a_pend <= 1'b0;
    else        a_pend <= a_fire;
  end

  word_t ent_data [DEPTH];
  word_t ent_lmask [DEPTH];
  logic  ent_live [DEPTH];
  word_t gm_q [NUM_GM];
  word_t cr_q [NUM_CR];

  tcam_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wk), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_live(wr_live),
    .ent_data(ent_data), .ent_lmask(ent_lmask), .ent_live(ent_live)
  );

  tcam_regs #(.NUM_GM(NUM_GM), .NUM_CR(NUM_CR)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wk),
    .wr_gm_idx(wr_addr[GM_W-1:0]), .wr_cr_idx(wr_addr[CR_W-1:0]),
    .wr_data(wr_data), .cmp_fire(b_fire), .cmp_pair(cr_pair), .cmp_key(key_in),
    .gm_q(gm_q), .cr_q(cr_q)
  );

  assign cr_rd_data = cr_q[cr_rd_idx];

  // compare in cycle A against pre-edge table state
  word_t gm_eff;
  logic [DEPTH-1:0] hit_vec;
  assign gm_eff = pair_mask(gm_q[{gm_pair, 1'b0}], gm_q[{gm_pair, 1'b1}]);

  tcam_match #(.DEPTH(DEPTH)) u_match (
    .key(key_in), .gmask(gm_eff), .ent_data(ent_data), .ent_lmask(ent_lmask),
    .ent_live(ent_live), .hit_vec(hit_vec)
  );

  logic             s1_vld;
  logic [DEPTH-1:0] s1_vec;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
      s1_vec <= '0;
    end else begin
      s1_vld <= a_fire;
      s1_vec <= a_fire ? hit_vec : '0;
    end
  end

  logic [ADDR_W-1:0] pe_idx;
  logic              pe_any;
  tcam_prienc #(.DEPTH(DEPTH)) u_pe (.vec(s1_vec), .idx(pe_idx), .any(pe_any));

  logic [PIPE_W-1:0] s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s2_q <= '0;
    else        s2_q <= {s1_vld, s1_vld && pe_any, s1_vld ? pe_idx : '0};
  end

  // remaining fixed latency up to BASE_LAT edges after cycle A
  logic [PIPE_W-1:0] base_taps [BASE_LAT];
  tcam_shift #(.W(PIPE_W), .N(BASE_LAT - 1)) u_base (
    .clk(clk), .rst_n(rst_n), .din(s2_q), .taps(base_taps)
  );

  logic win_hit;
  assign {win_stb, win_hit, win_addr} = base_taps[BASE_LAT-1];

  // programmable extra delay of the valid/found strobes
  logic [1:0]      stb_taps [MAX_XL+1];
  logic [XL_W-1:0] xl_sel;
  assign xl_sel = (32'(extra_lat) > MAX_XL) ? XL_W'(MAX_XL) : extra_lat;

  tcam_shift #(.W(2), .N(MAX_XL)) u_stb (
    .clk(clk), .rst_n(rst_n), .din({win_stb, win_stb && win_hit}), .taps(stb_taps)
  );

  assign {res_valid, res_found} = stb_taps[xl_sel];
endmodule

// File: rtl/tcam_search_chk.sv
module tcam_search_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              a_fire,
  input logic              b_fire,
  input logic              win_stb,
  input logic              win_hit,
  input logic [ADDR_W-1:0] win_addr,
  input logic              res_valid,
  input logic              res_found
);
  logic [7:0] open_w, open_r;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_w <= '0;
      open_r <= '0;
    end else begin
      open_w <= open_w + 8'(a_fire) - 8'(win_stb);
      open_r <= open_r + 8'(win_stb) - 8'(res_valid);
    end
  end

  // R1
  b_after_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_fire |-> $past(a_fire));

  // R8
  stb_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_stb |=> !win_stb);

  // R5
  stb_has_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_stb |-> (open_w != 8'd0));

  // R6
  valid_has_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (open_r != 8'd0 || win_stb));

  // R7
  miss_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_stb && !win_hit) |-> (win_addr == '0));

  // R7
  found_in_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_found |-> res_valid);
endmodule

bind tcam_search_top tcam_search_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_fire(a_fire), .b_fire(b_fire),
  .win_stb(win_stb), .win_hit(win_hit), .win_addr(win_addr),
  .res_valid(res_valid), .res_found(res_found)
);

// File: tb/tcam_search_top_tb.sv
module tcam_search_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        srch_a = 0, srch_b = 0, wr_en = 0, wr_live = 0;
  logic [67:0] key_in = '0, wr_data = '0;
  logic [1:0]  gm_pair = '0, cr_pair = '0, wr_kind = '0;
  logic [5:0]  wr_addr = '0;
  logic [2:0]  extra_lat = '0, cr_rd_idx = '0;
  logic [67:0] cr_rd_data;
  logic [5:0]  win_addr;
  logic        win_stb, res_valid, res_found;

  tcam_search_top u_dut (.*);

  always #4ns clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit mon_on = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // reference model
  logic [67:0] m_data [64];
  logic [67:0] m_lm [64];
  bit          m_live [64];
  logic [67:0] m_gm [8];
  logic [67:0] m_cr [8];

  // expectation queues
  int    wq_addr [512];
  int    wq_cyc [512];
  string wq_tag [512];
  int    wq_rd = 0, wq_wr = 0;
  bit    rq_fnd [512];
  int    rq_cyc [512];
  string rq_tag [512];
  int    rq_rd = 0, rq_wr = 0;

  task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [67:0] fkey(int i);
    logic [31:0] h;
    h = 32'(i) * 32'h9E37_79B9;
    return {4'hA, h, 32'(i)};
  endfunction

  function automatic int ref_idx(logic [67:0] key, int gp);
    logic [67:0] g;
    g = m_gm[2*gp] | m_gm[2*gp+1];
    for (int i = 0; i < 64; i++)
      if (m_live[i] && (((key ^ m_data[i]) & ~(m_lm[i] | g)) == '0)) return i;
    return -1;
  endfunction

  task automatic model_write(int k, int a, logic [67:0] d, bit l);
    case (k)
      0: begin m_data[a] = d; m_live[a] = l; end
      1: m_lm[a] = d;
      2: m_gm[a % 8] = d;
      default: m_cr[a % 8] = d;
    endcase
  endtask

  task automatic drive_write(int k, int a, logic [67:0] d, bit l);
    wr_en = 1; wr_kind = 2'(k); wr_addr = 6'(a); wr_data = d; wr_live = l;
  endtask

  task automatic do_write(int k, int a, logic [67:0] d, bit l);
    drive_write(k, a, d, l);
    @(negedge clk);
    wr_en = 0;
    model_write(k, a, d, l);
  endtask

  // two-cycle command, optional host write in cycle A (wb=0) or cycle B (wb=1)
  task automatic issue(logic [67:0] key, int gp, int cp, string tag,
                       bit dw = 0, bit wb = 0, int wk = 0, int wa = 0,
                       logic [67:0] wd = '0, bit wl = 0);
    int e;
    e = ref_idx(key, gp);
    wq_addr[wq_wr] = (e < 0) ? 0 : e; wq_cyc[wq_wr] = cyc + 6; wq_tag[wq_wr] = tag; wq_wr++;
    rq_fnd[rq_wr] = (e >= 0); rq_cyc[rq_wr] = cyc + 6 + int'(extra_lat);
    rq_tag[rq_wr] = tag; rq_wr++;
    srch_a = 1; key_in = key; gm_pair = 2'(gp);
    if (dw && !wb) drive_write(wk, wa, wd, wl);
    @(negedge clk);
    wr_en = 0;
    if (dw && !wb) model_write(wk, wa, wd, wl);
    srch_a = 0; srch_b = 1; cr_pair = 2'(cp);
    if (dw && wb) drive_write(wk, wa, wd, wl);
    @(negedge clk);
    srch_b = 0; wr_en = 0;
    if (dw && wb) model_write(wk, wa, wd, wl);
    m_cr[2*cp] = key; m_cr[2*cp+1] = key;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_crs(string tag);
    for (int i = 0; i < 8; i++) begin
      cr_rd_idx = 3'(i);
      #1ns;
      chk(cr_rd_data === m_cr[i], tag, 128'(cr_rd_data), 128'(m_cr[i]));
    end
  endtask

  // result monitor
  always @(negedge clk) if (mon_on) begin
    if (win_stb) begin
      if (wq_rd == wq_wr) chk(0, "R1 unexpected win_stb", 128'(cyc), 128'(0));
      else begin
        chk(win_addr == 6'(wq_addr[wq_rd]) && cyc == wq_cyc[wq_rd],
            {wq_tag[wq_rd], " win cycle/addr"},
            {64'(cyc), 64'(win_addr)}, {64'(wq_cyc[wq_rd]), 64'(wq_addr[wq_rd])});
        wq_rd++;
      end
    end else if (wq_rd != wq_wr && wq_cyc[wq_rd] <= cyc) begin
      chk(0, {"R5 missing win_stb ", wq_tag[wq_rd]}, 128'(cyc), 128'(wq_cyc[wq_rd]));
      wq_rd++;
    end
    if (res_valid) begin
      if (rq_rd == rq_wr) chk(0, "R6 unexpected res_valid", 128'(cyc), 128'(0));
      else begin
        chk(res_found == rq_fnd[rq_rd] && cyc == rq_cyc[rq_rd],
            {rq_tag[rq_rd], " R6 res cycle/found"},
            {64'(cyc), 64'(res_found)}, {64'(rq_cyc[rq_rd]), 64'(rq_fnd[rq_rd])});
        rq_rd++;
      end
    end else begin
      if (res_found) chk(0, "R7 found without valid", 128'(1), 128'(0));
      if (rq_rd != rq_wr && rq_cyc[rq_rd] <= cyc) begin
        chk(0, {"R6 missing res_valid ", rq_tag[rq_rd]}, 128'(cyc), 128'(rq_cyc[rq_rd]));
        rq_rd++;
      end
    end
  end

  initial begin
    logic [67:0] kx;
    for (int i = 0; i < 64; i++) begin m_data[i] = '0; m_lm[i] = '0; m_live[i] = 0; end
    for (int i = 0; i < 8; i++) begin m_gm[i] = '0; m_cr[i] = '0; end
    idle(3);
    // R11 reset state
    chk(win_stb === 0 && res_valid === 0 && res_found === 0, "R11 strobes in reset",
        {win_stb, res_valid, res_found}, 0);
    rst_n = 1;
    idle(1);
    mon_on = 1;
    check_crs("R11 comparand reset");
    // R11/R7: empty table misses but still reports valid
    issue(fkey(0), 0, 0, "R11 R7 empty miss");
    idle(10);

    // R9 fill table, R3/R8 back-to-back exhaustive sweep
    for (int i = 0; i < 64; i++) do_write(0, i, fkey(i), 1);
    extra_lat = 3'd2;
    for (int i = 0; i < 64; i++) issue(fkey(63 - i), i % 4, i % 4, "R8 R3 sweep");
    idle(14);
    check_crs("R4 after sweep");

    // R3 duplicate: lowest index wins; R2 dead entry skipped
    do_write(0, 40, fkey(10), 1);
    issue(fkey(10), 0, 0, "R3 duplicate");
    do_write(0, 10, fkey(10), 0);
    issue(fkey(10), 0, 0, "R2 dead entry");
    do_write(0, 10, fkey(10), 1);
    do_write(0, 40, fkey(40), 1);

    // R2 local mask
    do_write(1, 5, 68'hFF, 0);
    issue(fkey(5) ^ 68'h3C, 0, 1, "R2 local mask hit");
    issue(fkey(5) ^ 68'h100, 0, 1, "R2 local mask miss");
    do_write(1, 5, 68'h0, 0);

    // R2 global mask pair, both registers and single-register OR
    do_write(2, 4, {36'hF_FFFF_FFFF, 32'h0}, 0);
    do_write(2, 5, {36'hF_FFFF_FFFF, 32'h0}, 0);
    kx = {36'h1_2345_6789, 32'd7};
    issue(kx, 2, 0, "R2 global pair hit");
    issue(kx, 0, 0, "R2 global pair 0 miss");
    do_write(2, 6, {36'hF_FFFF_FFFF, 32'h0}, 0);
    issue({36'h9_8765_4321, 32'd44}, 3, 0, "R2 global odd-zero OR");
    idle(14);

    // R6 extra latency sweep
    for (int x = 0; x <= 7; x++) begin
      extra_lat = 3'(x);
      idle(1);
      issue(fkey(20 + x), 0, 0, "R6 latency sweep");
      issue({68{1'b1}}, 0, 0, "R6 R7 latency miss");
      idle(16);
    end

    // R4 comparand pair write
    issue(fkey(33), 0, 2, "R4 comparand");
    check_crs("R4 comparand pair");

    // R1 lone cycle B is ignored
    idle(12);
    srch_b = 1; key_in = {68{1'b1}}; cr_pair = 2'd3;
    @(negedge clk);
    srch_b = 0;
    idle(12);
    check_crs("R1 lone cycle B");
    // R1 srch_a held for two cycles: second cycle is not a new command
    srch_a = 1; key_in = fkey(9); gm_pair = 0;
    wq_addr[wq_wr] = 9; wq_cyc[wq_wr] = cyc + 6; wq_tag[wq_wr] = "R1 held A"; wq_wr++;
    rq_fnd[rq_wr] = 1; rq_cyc[rq_wr] = cyc + 6 + int'(extra_lat); rq_tag[rq_wr] = "R1 held A"; rq_wr++;
    @(negedge clk);
    @(negedge clk);
    srch_a = 0;
    idle(16);

    // R10 entry write in cycle A does not affect that search
    kx = 68'h5_5555_5555_5555_5555;
    issue(kx, 0, 0, "R10 write in cycle A", 1, 0, 0, 0, kx, 1);
    issue(kx, 0, 0, "R10 following search");
    // R4/R10 host comparand write in cycle B loses to the search
    issue(fkey(61), 0, 1, "R4 collide in B", 1, 1, 3, 2, 68'hDEAD, 0);
    idle(16);
    check_crs("R4 R10 collision");

    chk(wq_rd == wq_wr && rq_rd == rq_wr, "R5 R6 drained", {64'(wq_wr - wq_rd), 64'(rq_wr - rq_rd)}, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000us;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule